// File: doc/BRIEF.md
# Composite Video Sync-Referenced Gain Controller

This block closes a digital gain loop around the programmable amplifier that sits ahead of a composite video ADC. It runs in the ADC's free-running sample clock domain. Its inputs are the 9-bit unsigned samples, taken after back-porch clamping, together with a sync-pulse gate, a back-porch gate and the ADC overflow flag. Its output is a 6-bit gain code for the amplifier. The code range is wide enough for the external amplifier to span the roughly 3:1 spread of input amplitudes, about 0.6 to 1.8 V peak-to-peak.

Once per video line the block measures how deep the sync tip falls below the back-porch level and compares that depth with a programmable target. It then moves the gain code by at most one step toward the target. Independently of this, an ADC overflow can force a reduce-only decrement.

A 2-bit policy selector picks one of four modes:
- sync depth plus overflow,
- sync depth alone,
- overflow alone, with slow recovery,
- a fixed code taken from a configuration input.

Top module: `cvbs_agc_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the gain code loads `fixed_gain_i`, the active mode loads `mode_i`, and all per-line measurement and overflow history is cleared.
- R2: A line boundary is a cycle in which `sync_gate_i` is high and was low in the previous cycle; the first high cycle after reset also counts. The sync depth of a line is the floor mean of the first 8 samples with `porch_gate_i` high and `sync_gate_i` low, minus the minimum sample seen with `sync_gate_i` high (boundary cycle included), clamped at 0.
- R3: In modes 00 and 01, at a boundary whose previous line was measured, the gain code rises by 1 if depth + 2 < `target_i` and falls by 1 if depth > `target_i` + 2. Otherwise it holds. The new code appears one cycle after the boundary.
- R4: A line with fewer than 8 qualifying porch samples, or no line at all (the first boundary after reset), produces no sync-loop step.
- R5: In mode 01, `ovf_i` has no effect on the gain code.
- R6: In modes 00 and 10, `ovf_i` high lowers the gain code by 1 in the next cycle, at most once per line. The boundary cycle belongs to the new line.
- R7: In mode 10 the sync loop is inactive. After 64 consecutive completed lines with no `ovf_i` at all, the gain code rises by 1 and the count restarts. The count is held at zero in the other modes.
- R8: The gain code saturates at 0 and 63 and never wraps. Simultaneous adjustments are summed first and then clamped.
- R9: In mode 11 the gain code equals `fixed_gain_i` from the previous cycle, whatever the sync and overflow inputs do.
- R10: Mode encoding is 00 combined, 01 sync-only, 10 overflow-only, 11 fixed. `mode_i` is sampled only at a line boundary and governs from the following cycle.
- R11: Outside mode 11, the gain code changes only in the cycle after a line boundary or after an accepted overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 9 | Clamped unsigned ADC sample |
| sync_gate_i | input | 1 | High during the sync pulse |
| porch_gate_i | input | 1 | High during the back porch |
| ovf_i | input | 1 | ADC overflow flag |
| mode_i | input | 2 | Regulation policy select |
| fixed_gain_i | input | 6 | Gain code for mode 11 and reset |
| target_i | input | 9 | Desired sync depth in ADC codes |
| gain_o | output | 6 | Gain code to the amplifier |

## Verification
The bench steps through the dead-band edges at target − 2, − 3, + 2 and + 3. A comparator that is off by one there would step when it should hold, or hold when it should step.

It feeds lines carrying two overflow pulses each. A design without the once-per-line limit would drop the code by two per line.

It also switches mode in mid-line and checks that the code does not follow the fixed value before the next boundary. It runs exactly 63 and then 64 clean lines in overflow-only mode, so an off-by-one in the recovery counter shows up as an early or late increment.

Short-porch lines and pushes against both saturation limits complete the set. A wrapping code would jump from 63 to 0 or from 0 to 63.

// File: rtl/agc_pkg.sv
// Shared definitions for the composite video gain controller.
// Assumes: two-bit policy field, encoding fixed by the configuration map.
package agc_pkg;

    typedef enum logic [1:0] {
        AGC_COMBINED = 2'b00,
        AGC_SYNC     = 2'b01,
        AGC_OVF      = 2'b10,
        AGC_FIXED    = 2'b11
    } agc_mode_e;

    // True when the sync-depth loop may move the gain in this policy.
    function automatic logic uses_sync_loop(input agc_mode_e m);
        return (m == AGC_COMBINED) || (m == AGC_SYNC);
    endfunction

    // True when overflow events may pull the gain down in this policy.
    function automatic logic uses_ovf_loop(input agc_mode_e m);
        return (m == AGC_COMBINED) || (m == AGC_OVF);
    endfunction

endpackage

// File: rtl/agc_line_meter.sv
// Per-line sync-depth meter.
// Detects the line boundary (rising sync gate), tracks the sync tip minimum
// and the back-porch sum of the first 2**PORCH_LOG2 samples, and at the
// boundary compares the finished line's depth with the target.
// Assumes the sync pulse precedes the back porch within a line and that a
// sample inside both gates belongs to the sync pulse.
module agc_line_meter #(
    parameter int SW         = 9,
    parameter int PORCH_LOG2 = 3,
    parameter int DEAD_BAND  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample_i,
    input  logic          sync_gate_i,
    input  logic          porch_gate_i,
    input  logic [SW-1:0] target_i,
    output logic          line_start_o,
    output logic          raise_o,
    output logic          lower_o
);

    localparam int PORCH_N = 1 << PORCH_LOG2;
    localparam int CW      = PORCH_LOG2 + 1;
    localparam int ACC_W   = SW + PORCH_LOG2;
    localparam int DW      = ACC_W + 1;

    logic             sync_q;
    logic             have_tip;
    logic [SW-1:0]    tip_min;
    logic [ACC_W-1:0] porch_sum;
    logic [CW-1:0]    porch_cnt;

    logic             porch_full;
    logic [DW-1:0]    avg_w, tip_w, depth_w, tgt_w, band_w;
    logic             meas_ok;

    assign line_start_o = sync_gate_i & ~sync_q;
    assign porch_full   = (porch_cnt == CW'(PORCH_N));

    // Depth of the completed line and its comparison against the target band.
    always_comb begin
        avg_w   = DW'(porch_sum >> PORCH_LOG2);
        tip_w   = DW'(tip_min);
        depth_w = (avg_w > tip_w) ? (avg_w - tip_w) : '0;
        tgt_w   = DW'(target_i);
        band_w  = DW'(DEAD_BAND);
        meas_ok = line_start_o & have_tip & porch_full;
        raise_o = meas_ok && ((depth_w + band_w) < tgt_w);
        lower_o = meas_ok && (depth_w > (tgt_w + band_w));
    end

    // Delayed sync gate for boundary detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_gate_i;
    end

    // Sync tip minimum tracker, restarted at every boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_tip <= 1'b0;
            tip_min  <= '0;
        end else if (line_start_o) begin
            have_tip <= 1'b1;
            tip_min  <= sample_i;
        end else if (sync_gate_i && (sample_i < tip_min)) begin
            tip_min  <= sample_i;
        end
    end

    // Back-porch accumulator over the first PORCH_N qualifying samples.
    always_ff @(posedge clk) begin
        if (!rst_n || line_start_o) begin
            porch_sum <= '0;
            porch_cnt <= '0;
        end else if (porch_gate_i && !sync_gate_i && !porch_full) begin
            porch_sum <= porch_sum + ACC_W'(sample_i);
            porch_cnt <= porch_cnt + 1'b1;
        end
    end

    // R2
    porch_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        porch_cnt <= CW'(PORCH_N));

    // R2
    boundary_clears_porch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |=> (porch_cnt == '0) || (porch_cnt == CW'(1)));

endmodule

// File: rtl/agc_gain_core.sv
// Gain code register and regulation policy.
// Combines the per-line sync step, the reduce-only overflow override and the
// slow overflow-mode recovery, then saturates the result. The policy is
// latched at each line boundary and governs from the next cycle.
// Assumes line_start_i, raise_i and lower_i come from the line meter in the
// same cycle.
module agc_gain_core
    import agc_pkg::*;
#(
    parameter int GW          = 6,
    parameter int QUIET_LINES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start_i,
    input  logic          raise_i,
    input  logic          lower_i,
    input  logic          ovf_i,
    input  logic [1:0]    mode_i,
    input  logic [GW-1:0] fixed_gain_i,
    output logic [GW-1:0] gain_o
);

    localparam int            QW   = $clog2(QUIET_LINES);
    localparam int            EW   = GW + 2;
    localparam logic [EW-1:0] GMAX = EW'((1 << GW) - 1);

    agc_mode_e     act_mode;
    logic [GW-1:0] gain_r;
    logic          ovf_used;
    logic          line_ovf;
    logic [QW-1:0] quiet_cnt;

    logic          sync_up, sync_dn, ovf_dec, quiet_inc;
    logic [EW-1:0] inc_w, dec_w, plus_w, diff_w;
    logic [GW-1:0] gain_nxt;

    assign gain_o = gain_r;

    // Decide this cycle's adjustments from the active policy.
    always_comb begin
        sync_up   = uses_sync_loop(act_mode) & raise_i;
        sync_dn   = uses_sync_loop(act_mode) & lower_i;
        ovf_dec   = uses_ovf_loop(act_mode) & ovf_i & (line_start_i | ~ovf_used);
        quiet_inc = (act_mode == AGC_OVF) & line_start_i & ~line_ovf
                    & (quiet_cnt == QW'(QUIET_LINES - 1));
    end

    // Sum the adjustments and clamp into the code range.
    always_comb begin
        inc_w  = EW'(sync_up) + EW'(quiet_inc);
        dec_w  = EW'(sync_dn) + EW'(ovf_dec);
        plus_w = EW'(gain_r) + inc_w;
        diff_w = '0;
        if (plus_w >= dec_w) diff_w = plus_w - dec_w;
        if (diff_w > GMAX)   diff_w = GMAX;
        gain_nxt = diff_w[GW-1:0];
    end

    // Gain register: fixed in mode 11, regulated otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                    gain_r <= fixed_gain_i;
        else if (act_mode == AGC_FIXED) gain_r <= fixed_gain_i;
        else                           gain_r <= gain_nxt;
    end

    // Policy latch, updated only at line boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)            act_mode <= agc_mode_e'(mode_i);
        else if (line_start_i) act_mode <= agc_mode_e'(mode_i);
    end

    // Per-line overflow history: accepted decrement and any raw overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_used <= 1'b0;
            line_ovf <= 1'b0;
        end else if (line_start_i) begin
            ovf_used <= ovf_dec;
            line_ovf <= ovf_i;
        end else begin
            ovf_used <= ovf_used | ovf_dec;
            line_ovf <= line_ovf | ovf_i;
        end
    end

    // Count consecutive clean lines for overflow-mode recovery.
    always_ff @(posedge clk) begin
        if (!rst_n || act_mode != AGC_OVF) quiet_cnt <= '0;
        else if (line_start_i) begin
            if (line_ovf || quiet_inc) quiet_cnt <= '0;
            else                       quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // R5
    sync_mode_ovf_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == AGC_SYNC && !line_start_i) |=> $stable(gain_r));

    // R6
    one_ovf_per_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == AGC_OVF && ovf_used && !line_start_i) |=> $stable(gain_r));

    // R9
    fixed_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == AGC_FIXED) |=> (gain_r == $past(fixed_gain_i)));

    // R10
    mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start_i |=> $stable(act_mode));

    // R8
    bounded_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode != AGC_FIXED) |=>
        (((gain_r >= $past(gain_r)) ? (gain_r - $past(gain_r))
                                    : ($past(gain_r) - gain_r)) <= GW'(2)));

endmodule

// File: rtl/cvbs_agc_ctrl.sv
// Composite video automatic gain controller, top level.
// Wires the per-line sync-depth meter to the gain policy core. Everything
// runs on the ADC sample clock; reset is synchronous and active low.
module cvbs_agc_ctrl #(
    parameter int SW          = 9,
    parameter int GW          = 6,
    parameter int PORCH_LOG2  = 3,
    parameter int DEAD_BAND   = 2,
    parameter int QUIET_LINES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample_i,
    input  logic          sync_gate_i,
    input  logic          porch_gate_i,
    input  logic          ovf_i,
    input  logic [1:0]    mode_i,
    input  logic [GW-1:0] fixed_gain_i,
    input  logic [SW-1:0] target_i,
    output logic [GW-1:0] gain_o
);

    logic line_start, raise, lower;

    agc_line_meter #(
        .SW(SW), .PORCH_LOG2(PORCH_LOG2), .DEAD_BAND(DEAD_BAND)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .sync_gate_i(sync_gate_i), .porch_gate_i(porch_gate_i),
        .target_i(target_i), .line_start_o(line_start),
        .raise_o(raise), .lower_o(lower)
    );

    agc_gain_core #(
        .GW(GW), .QUIET_LINES(QUIET_LINES)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .line_start_i(line_start),
        .raise_i(raise), .lower_i(lower), .ovf_i(ovf_i),
        .mode_i(mode_i), .fixed_gain_i(fixed_gain_i), .gain_o(gain_o)
    );

    // R11
    gain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !ovf_i && u_core.act_mode != agc_pkg::AGC_FIXED)
        |=> $stable(gain_o));

endmodule

// File: tb/sim_cvbs_agc_ctrl.sv
// Bench for cvbs_agc_ctrl: behavioural per-cycle model plus directed checks.
module sim_cvbs_agc_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] sample = '0;
    logic       sync_g = 1'b0, porch_g = 1'b0, ovf = 1'b0;
    logic [1:0] mode = 2'b01;
    logic [5:0] fixed = 6'd20;
    logic [8:0] target = 9'd100;
    logic [5:0] gain;

    int vectors = 0, errors = 0, cycles = 0;
    string cur_req = "R1";
    bit started = 0;

    // behavioural reference state
    int m_gain, m_mode, m_psync, m_have, m_tip, m_sum, m_pcnt;
    int m_used, m_lovf, m_quiet;

    always #(CLK_PERIOD/2) clk = ~clk;

    cvbs_agc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .sync_gate_i(sync_g),
        .porch_gate_i(porch_g), .ovf_i(ovf), .mode_i(mode),
        .fixed_gain_i(fixed), .target_i(target), .gain_o(gain)
    );

    // Reference model, evaluated on the inputs held since the last negedge.
    always @(posedge clk) begin
        int ls, up, dn, od, qi, ng, avg, depth;
        started = 1;
        if (!rst_n) begin
            m_gain = fixed; m_mode = mode; m_psync = 0; m_have = 0; m_tip = 0;
            m_sum = 0; m_pcnt = 0; m_used = 0; m_lovf = 0; m_quiet = 0;
        end else begin
            ls = (sync_g && !m_psync) ? 1 : 0;
            up = 0; dn = 0;
            if (ls && m_have && m_pcnt == 8) begin
                avg = m_sum / 8;
                depth = (avg > m_tip) ? avg - m_tip : 0;
                if (depth + 2 < target) up = 1;
                else if (depth > target + 2) dn = 1;
            end
            if (!(m_mode == 0 || m_mode == 1)) begin up = 0; dn = 0; end
            od = ((m_mode == 0 || m_mode == 2) && ovf && (ls || !m_used)) ? 1 : 0;
            qi = (m_mode == 2 && ls && !m_lovf && m_quiet == 63) ? 1 : 0;
            ng = m_gain + up + qi - dn - od;
            if (ng < 0) ng = 0;
            if (ng > 63) ng = 63;
            if (m_mode == 3) ng = fixed;
            if (m_mode != 2) m_quiet = 0;
            else if (ls) m_quiet = (m_lovf || qi) ? 0 : m_quiet + 1;
            if (ls) begin m_used = od; m_lovf = ovf; end
            else begin m_used = m_used | od; m_lovf = m_lovf | ovf; end
            if (ls) begin m_have = 1; m_tip = sample; end
            else if (sync_g && sample < m_tip) m_tip = sample;
            if (ls) begin m_sum = 0; m_pcnt = 0; end
            else if (porch_g && !sync_g && m_pcnt < 8) begin
                m_sum += sample; m_pcnt++;
            end
            if (ls) m_mode = mode;
            m_gain = ng;
            m_psync = sync_g;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            vectors++;
            if (int'(gain) != m_gain) begin
                errors++;
                $display("FAIL %s cycle %0d: gain %0d expected %0d",
                         cur_req, cycles, gain, m_gain);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: cycles %0d expected below 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic drive(input int s, input bit sg, input bit pg, input bit ov);
        @(negedge clk);
        sample = 9'(s); sync_g = sg; porch_g = pg; ovf = ov;
    endtask

    // One line: sync, gap, porch, active region with n_ovf overflow pulses.
    task automatic line(input int tip, input int porch, input int plen, input int n_ovf);
        for (int i = 0; i < 4; i++) drive(tip, 1, 0, 0);
        for (int i = 0; i < 2; i++) drive(porch, 0, 0, 0);
        for (int i = 0; i < plen; i++) drive(porch, 0, 1, 0);
        for (int i = 0; i < 4; i++) drive(300, 0, 0, (i == 0 && n_ovf > 0) || (i == 2 && n_ovf > 1));
    endtask

    task automatic lines(input int n, input int tip, input int porch, input int plen, input int n_ovf);
        for (int k = 0; k < n; k++) line(tip, porch, plen, n_ovf);
    endtask

    // Idle one cycle then compare the gain with a fixed expectation.
    task automatic expect_gain(input int exp, input string req);
        drive(300, 0, 0, 0);
        vectors++;
        if (int'(gain) != exp) begin
            errors++;
            $display("FAIL %s: gain %0d expected %0d", req, gain, exp);
        end
    endtask

    initial begin
        // R1 reset loads the fixed code
        cur_req = "R1";
        repeat (3) drive(300, 0, 0, 0);
        expect_gain(20, "R1");
        rst_n = 1'b1;
        // R3 shallow sync -> one step up per measured line, first boundary unmeasured (R4)
        cur_req = "R3";
        lines(6, 100, 120, 10, 0);
        expect_gain(25, "R3");
        // R3 dead band edges with depth 100
        target = 9'd102; lines(3, 100, 200, 10, 0); expect_gain(26, "R3");
        target = 9'd103; lines(3, 100, 200, 10, 0); expect_gain(29, "R3");
        target = 9'd97;  lines(3, 100, 200, 10, 0); expect_gain(26, "R3");
        target = 9'd98;  lines(3, 100, 200, 10, 0); expect_gain(26, "R3");
        // R5 overflow ignored in sync-only mode
        cur_req = "R5";
        lines(3, 100, 200, 10, 2); expect_gain(26, "R5");
        // R4 short porch gives no step
        cur_req = "R4";
        target = 9'd150; lines(3, 100, 200, 7, 0); expect_gain(27, "R4");
        // R6 combined mode, two pulses per line, one decrement each
        cur_req = "R6";
        target = 9'd100; mode = 2'b00;
        lines(3, 100, 200, 10, 2); expect_gain(24, "R6");
        // R10 mid-line mode change waits for the boundary
        cur_req = "R10";
        mode = 2'b11; fixed = 6'd50;
        expect_gain(24, "R10");
        // R9 fixed mode follows the register and ignores overflow
        cur_req = "R9";
        lines(1, 100, 200, 10, 2); expect_gain(50, "R9");
        fixed = 6'd10; drive(300, 0, 0, 1); expect_gain(10, "R9");
        // R8 upper saturation
        cur_req = "R8";
        fixed = 6'd61; drive(300, 0, 0, 0);
        mode = 2'b01; target = 9'd400;
        lines(6, 100, 200, 10, 0); expect_gain(63, "R8");
        // R8 lower saturation in overflow mode
        mode = 2'b11; fixed = 6'd2; lines(1, 100, 200, 10, 0);
        mode = 2'b10; lines(4, 100, 200, 10, 2); expect_gain(0, "R8");
        // R7 recovery after 64 clean lines, not 63
        cur_req = "R7";
        lines(64, 100, 200, 10, 0); expect_gain(0, "R7");
        lines(1, 100, 200, 10, 0);  expect_gain(1, "R7");
        // R11 quiet cycles hold the code
        cur_req = "R11";
        repeat (5) drive(250, 0, 1, 0);
        expect_gain(1, "R11");
        // R1 reset again mid-run
        cur_req = "R1";
        fixed = 6'd33; rst_n = 1'b0;
        drive(300, 0, 0, 0); drive(300, 0, 0, 0);
        expect_gain(33, "R1");
        rst_n = 1'b1;
        cur_req = "R2";
        mode = 2'b01; target = 9'd100;
        lines(3, 180, 120, 10, 0); expect_gain(35, "R2");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule